// File: doc/BRIEF.md
# LCD Drive Level Selector

This block keeps one display line in an 80-bit register and turns every stored bit into a 2-bit code. The code names which of four bias levels the analog switch of that channel connects to the panel. A line-strobe input comes from the display controller. The block resynchronises it to its own clock and detects its high-to-low transition. On that transition it copies the 80-bit input word into the line register.

The channel codes are produced combinationally from four things: the line register, the polarity-alternation input, the driver-role select and the active-low blanking input. The role select chooses between two mappings. One is for data (segment) drivers. The other is for scan (common) drivers, where a 1 marks the selected row. Blanking forces every channel to the first level code and leaves the stored line untouched. The analog switches and the bias voltages sit outside this block.

Top module: `lcd_level_sel`

## Requirements
- R1: A synchronous active-high reset clears the line register to all zeros. After reset, with scan role, polarity low and blanking released, every channel reads code 2'b10.
- R2: A high-to-low transition of `line_clk` loads `pix_word` into the line register at the SYNC_STAGES-th rising clock edge after the first clock edge that sees `line_clk` low. With the default of 2, the register still holds the old line after that first edge plus one more, and holds the new line after the edge that follows.
- R3: A rising transition of `line_clk`, or a `line_clk` held steady, never loads the register. Changes on `pix_word` at those times are ignored.
- R4: In data-driver role (`col_mode`=1) the codes are V1=2'b00, V2=2'b01, V3=2'b10 and V4=2'b11. A stored 1 gives V1 when `polarity` is 0 and V2 when it is 1. A stored 0 gives V3 when `polarity` is 0 and V4 when it is 1.
- R5: In scan-driver role (`col_mode`=0), using the same codes, a stored 1 gives V2 when `polarity` is 0 and V1 when it is 1. A stored 0 gives V3 when `polarity` is 0 and V4 when it is 1.
- R6: While `disp_on_n`... is low, that is while `disp_en` is 0, every channel reads V1 (2'b00) regardless of data, role and polarity.
- R7: Blanking does not alter the line register. When `disp_en` returns to 1, the outputs again reflect the line stored before blanking.
- R8: Changes on `polarity`, `col_mode` and `disp_en` reach `lvl_codes` in the same cycle, without a clock edge and without reloading the line.
- R9: Channel i uses line bit `pix_word[i]`, and its code appears on `lvl_codes[2*i+1:2*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Line strobe; its falling transition loads the line |
| pix_word | input | CHANNELS | One line of pixel bits, bit i for channel i |
| polarity | input | 1 | Drive polarity alternation |
| col_mode | input | 1 | 1 selects data-driver mapping, 0 scan-driver mapping |
| disp_en | input | 1 | Active-low blanking: 0 forces every channel to V1 |
| lvl_codes | output | 2*CHANNELS | Two-bit level code per channel |

## Verification
The bench samples the output the cycle before the load edge and the cycle of the load edge. This exposes a synchroniser that is one stage too short or too long, and a design that loads on the rising strobe. It drives all four combinations of data and polarity in both roles. A design that swaps V1 and V2 in scan role would pass the data-driver checks and fail there. Blanking is applied over a line whose pattern differs from the reset value, and then released. A design that clears or reloads the register while blanked would come back with the wrong pattern. One-hot and asymmetric words catch reversed or shifted channel order.

// File: rtl/lcd_lvl_pkg.sv
package lcd_lvl_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_V1 = 2'b00;
  localparam lvl_t LVL_V2 = 2'b01;
  localparam lvl_t LVL_V3 = 2'b10;
  localparam lvl_t LVL_V4 = 2'b11;

  // Data role: on pixels sit on V1/V2, off pixels on V3/V4, polarity picks within pair.
  // Scan role: selected row alternates V2 (pol 0) / V1 (pol 1); unselected V3/V4.
  function automatic lvl_t pick_level(input logic px, input logic col,
                                      input logic pol, input logic show);
    lvl_t r;
    if (!show) begin
      r = LVL_V1;
    end else if (col) begin
      if (px) r = pol ? LVL_V2 : LVL_V1;
      else    r = pol ? LVL_V4 : LVL_V3;
    end else begin
      if (px) r = pol ? LVL_V1 : LVL_V2;
      else    r = pol ? LVL_V4 : LVL_V3;
    end
    return r;
  endfunction

endpackage

// File: rtl/lcd_fall_detect.sv
module lcd_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic fall_pulse
);

  logic synced;
  logic prev_q;

  generate
    if (STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b0;
        else     s_q <= strobe_in;
      end
      assign synced = s_q;
    end else begin : g_many
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= {s_q[STAGES-2:0], strobe_in};
      end
      assign synced = s_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= synced;
  end

  assign fall_pulse = prev_q & ~synced;

  // R3: a falling detection lasts exactly one cycle, never repeats while held low
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/lcd_line_latch.sv
module lcd_line_latch #(
  parameter int WIDTH = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R2: a load captures the word present at the load edge
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));

  // R3 / R7: without a load the stored line never moves
  assert_hold_line_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_lvl_pkg::*;
#(
  parameter int CHANNELS = 80
) (
  input  logic [CHANNELS-1:0]   line_bits,
  input  logic                  pol,
  input  logic                  col,
  input  logic                  show,
  output logic [2*CHANNELS-1:0] codes
);

  generate
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
      assign codes[2*ch +: 2] = pick_level(line_bits[ch], col, pol, show);
    end
  endgenerate

endmodule

// File: rtl/lcd_level_sel.sv
module lcd_level_sel
  import lcd_lvl_pkg::*;
#(
  parameter int CHANNELS    = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_clk,
  input  logic [CHANNELS-1:0]   pix_word,
  input  logic                  polarity,
  input  logic                  col_mode,
  input  logic                  disp_en,
  output logic [2*CHANNELS-1:0] lvl_codes
);

  localparam int LAST = CHANNELS - 1;

  logic                line_fall;
  logic [CHANNELS-1:0] line_q;

  lcd_fall_detect #(.STAGES(SYNC_STAGES)) u_fall (
    .clk        (clk),
    .rst        (rst),
    .strobe_in  (line_clk),
    .fall_pulse (line_fall)
  );

  lcd_line_latch #(.WIDTH(CHANNELS)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .load (line_fall),
    .d    (pix_word),
    .q    (line_q)
  );

  lcd_level_map #(.CHANNELS(CHANNELS)) u_map (
    .line_bits (line_q),
    .pol       (polarity),
    .col       (col_mode),
    .show      (disp_en),
    .codes     (lvl_codes)
  );

  // R6: blanking drives every channel to the V1 code
  assert_blank_all_v1_R6: assert property (@(posedge clk) disable iff (rst)
    !disp_en |-> (lvl_codes == '0));

  // R4: data role, channel 0 on pixel sits in the V1/V2 pair
  assert_col_on_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (disp_en && col_mode && line_q[0]) |-> (lvl_codes[1] == 1'b0));

  // R5: scan role, last channel selected row alternates against polarity
  assert_scan_sel_R5: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !col_mode && line_q[LAST]) |->
      (lvl_codes[2*LAST +: 2] == (polarity ? LVL_V1 : LVL_V2)));

  // R5 / R4: an off pixel in either role follows polarity within V3/V4
  assert_off_pixel_R5: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !line_q[0]) |-> (lvl_codes[1:0] == (polarity ? LVL_V4 : LVL_V3)));

endmodule

// File: tb/lcd_level_sel_bench.sv
`timescale 1ns/1ps
module lcd_level_sel_bench;

  localparam int CH = 80;

  logic          clk = 1'b0;
  logic          rst;
  logic          line_clk;
  logic [CH-1:0] pix_word;
  logic          polarity;
  logic          col_mode;
  logic          disp_en;
  logic [2*CH-1:0] lvl_codes;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  lcd_level_sel #(.CHANNELS(CH), .SYNC_STAGES(2)) u_lcd_level_sel (
    .clk       (clk),
    .rst       (rst),
    .line_clk  (line_clk),
    .pix_word  (pix_word),
    .polarity  (polarity),
    .col_mode  (col_mode),
    .disp_en   (disp_en),
    .lvl_codes (lvl_codes)
  );

  // Expected code from the requirement text (R4, R5, R6)
  function automatic logic [1:0] want(input logic px, input logic col,
                                      input logic pol, input logic en);
    if (!en) return 2'b00;
    if (col) return px ? (pol ? 2'b01 : 2'b00) : (pol ? 2'b11 : 2'b10);
    return px ? (pol ? 2'b00 : 2'b01) : (pol ? 2'b11 : 2'b10);
  endfunction

  task automatic check_line(input logic [CH-1:0] line, input string tag);
    logic [2*CH-1:0] exp;
    for (int i = 0; i < CH; i++) exp[2*i +: 2] = want(line[i], col_mode, polarity, disp_en);
    total++;
    if (lvl_codes !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, lvl_codes, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; line_clk = 1'b1; pix_word = '0;
    polarity = 1'b0; col_mode = 1'b0; disp_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Strobe falls at a negedge; load expected at the second posedge after the first.
  task automatic load_line(input logic [CH-1:0] w);
    @(negedge clk);
    line_clk = 1'b1;
    repeat (3) @(negedge clk);
    pix_word = w;
    line_clk = 1'b0;
    repeat (4) @(negedge clk);
    line_clk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_line('0, "R1 reset clears line, scan role reads V3");
  endtask

  task automatic t_latency();
    logic [CH-1:0] old_w = '0;
    logic [CH-1:0] new_w = {20{4'b1011}};
    col_mode = 1'b1;
    @(negedge clk);
    pix_word = new_w;
    line_clk = 1'b0;
    @(posedge clk);
    @(posedge clk); #1;
    check_line(old_w, "R2 line unchanged one edge early");
    @(posedge clk); #1;
    check_line(new_w, "R2 line loaded at sync latency edge");
    @(negedge clk);
    line_clk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_no_load();
    logic [CH-1:0] held = {20{4'b1011}};
    pix_word = ~held;
    repeat (5) @(negedge clk);
    check_line(held, "R3 steady high strobe ignores data");
    line_clk = 1'b0;
    repeat (6) @(negedge clk);
    pix_word = {CH{1'b1}};
    repeat (6) @(negedge clk);
    check_line(~held, "R3 data change while strobe low ignored");
    line_clk = 1'b1;
    repeat (6) @(negedge clk);
    check_line(~held, "R3 rising strobe does not load");
  endtask

  task automatic t_maps();
    logic [CH-1:0] w = {40{2'b10}};
    load_line(w);
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 2; p++) begin
        col_mode = c[0]; polarity = p[0];
        #1;
        check_line(w, c ? "R4 data role mapping" : "R5 scan role mapping");
      end
    end
  endtask

  task automatic t_blank();
    logic [CH-1:0] w = {16{5'b01101}};
    load_line(w);
    col_mode = 1'b0; polarity = 1'b1;
    @(negedge clk);
    disp_en = 1'b0;
    #1;
    check_line(w, "R6 blanking forces V1 same cycle (R8)");
    polarity = 1'b0; col_mode = 1'b1;
    repeat (4) @(negedge clk);
    check_line(w, "R6 blanking holds V1 across role and polarity");
    disp_en = 1'b1;
    #1;
    check_line(w, "R7 line intact after blanking");
  endtask

  task automatic t_combo_now();
    logic [CH-1:0] w = {40{2'b01}};
    load_line(w);
    @(negedge clk);
    col_mode = 1'b1; polarity = 1'b0;
    #1 check_line(w, "R8 role change immediate");
    polarity = 1'b1;
    #1 check_line(w, "R8 polarity change immediate");
  endtask

  task automatic t_order();
    logic [CH-1:0] w = '0;
    w[0] = 1'b1;
    col_mode = 1'b1; polarity = 1'b0;
    load_line(w);
    total++;
    if (lvl_codes[1:0] !== 2'b00 || lvl_codes[3:2] !== 2'b10) begin
      bad++;
      $display("FAIL R9 channel 0 position: actual=%b expected=1000", lvl_codes[3:0]);
    end
    w = '0;
    w[CH-1] = 1'b1;
    load_line(w);
    total++;
    if (lvl_codes[2*CH-1 -: 2] !== 2'b00 || lvl_codes[1:0] !== 2'b10) begin
      bad++;
      $display("FAIL R9 last channel position: actual=%b expected=00 (low %b exp 10)",
               lvl_codes[2*CH-1 -: 2], lvl_codes[1:0]);
    end
    check_line(w, "R9 full line one-hot top");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; line_clk = 1'b1; pix_word = '0;
    polarity = 1'b0; col_mode = 1'b0; disp_en = 1'b1;
    t_reset();
    t_latency();
    t_no_load();
    t_maps();
    t_blank();
    t_combo_now();
    t_order();
    do_reset();
    check_line('0, "R1 second reset clears loaded line");
    finish_run();
  end

endmodule